// File: doc/BRIEF.md
# Sprite Memory Page Copier

This block sits beside the processor's write bus and watches every store. A store to the trigger address starts a copy. The byte written there names a source page: page N covers the addresses from N×256 to N×256+255. The block reads that page one byte at a time, in rising address order, and writes each byte to one fixed data-port register of the video unit. While the copy runs it holds the processor in a stall.

Each byte costs two cycles: a read cycle followed by a write cycle. A full page therefore takes 512 stalled cycles. Every other processor store passes straight through to memory on the forward port. The store to the trigger address is held back from memory.

The memory read port has a fixed latency of one cycle. A byte requested in the read cycle is on `mem_rd_data` in the following write cycle, and it goes to the video port in that same cycle. The transfer timing is fixed, so the data paths are plain strobes with no valid/ready handshake. Neither the memory nor the video register can apply back-pressure.

Top module: `sprite_dma`

## Requirements
- R1: After reset `busy`, `cpu_stall`, `mem_rd_en`, `vid_wr_en` and `done` are 0, and `cycle_count` is 0.
- R2: A processor store to address 0x4014 made while idle starts a copy and is not forwarded (`fwd_wr_en` stays 0). Any other store appears unchanged on the forward port in the same cycle.
- R3: The trigger store lands in cycle t. Read k (k = 0..255) is issued in cycle t+1+2k, with `mem_rd_addr` = N×256+k, where N is the trigger data byte.
- R4: Write k is issued in cycle t+2+2k. It has `vid_wr_addr` = 0x2004 and `vid_wr_data` equal to `mem_rd_data` in that cycle.
- R5: Exactly 256 reads and 256 writes occur per trigger. They alternate, and a read and a write never share a cycle.
- R6: `cpu_stall` is 1 from cycle t+1 through cycle t+512 and 0 at other times. `busy` equals `cpu_stall` in every cycle.
- R7: A trigger store that arrives while a copy is running is ignored. The running copy keeps its source page and its sequence, and the store is still not forwarded.
- R8: `cycle_count` grows by exactly 512 when a copy completes. The new value is visible from cycle t+513.
- R9: `done` is a one-cycle pulse that coincides with the 256th write.
- R10: Page 0x00 and page 0xFF copy correctly; page 0xFF ends at source address 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor store strobe |
| cpu_wr_addr | input | 16 | Processor store address |
| cpu_wr_data | input | 8 | Processor store data |
| fwd_wr_en | output | 1 | Forwarded store strobe toward memory |
| fwd_wr_addr | output | 16 | Forwarded store address |
| fwd_wr_data | output | 8 | Forwarded store data |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| vid_wr_en | output | 1 | Write strobe to the video data register |
| vid_wr_addr | output | 16 | Destination address, always 0x2004 |
| vid_wr_data | output | 8 | Byte being written |
| cpu_stall | output | 1 | Holds the processor while copying |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Pulse on the final write |
| cycle_count | output | 32 | Total cycles spent copying |

## Verification
The bench sweeps source pages that include 0x00, 0xFF and values in between. In every cycle it compares each read address and each written byte against a memory model built from an arithmetic formula. A design that stopped one byte short or one byte late would fail on the read count and the `done` cycle. A design that let the page high byte wrap wrongly would fail at page 0xFF. A trigger store placed in the middle of a copy catches a design that restarts or switches pages, and also one that leaks that store to memory. Checking the forward port on ordinary stores and near-miss addresses catches a decoder that swallows the wrong stores. Checking `cycle_count` right after each copy catches a counter that steps by the wrong amount or updates at the wrong time.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/sdma_snoop.sv
module sdma_snoop #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              hit,
  output logic              fwd_wr_en,
  output logic [ADDR_W-1:0] fwd_wr_addr,
  output logic [DATA_W-1:0] fwd_wr_data
);
  // A store to the trigger address is claimed here and never reaches memory.
  always_comb begin
    hit         = cpu_wr_en && (cpu_wr_addr == TRIG_ADDR);
    fwd_wr_en   = cpu_wr_en && !hit;
    fwd_wr_addr = cpu_wr_addr;
    fwd_wr_data = cpu_wr_data;
  end
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic              last_wr,
  output logic              active
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  phase_e            phase_q;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      page_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          page_q  <= start_page;
          idx_q   <= '0;
          phase_q <= PH_READ;
        end
        PH_READ: phase_q <= PH_WRITE;
        PH_WRITE: begin
          if (idx_q == LAST_IDX) begin
            phase_q <= PH_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            phase_q <= PH_READ;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    active  = (phase_q != PH_IDLE);
    rd_en   = (phase_q == PH_READ);
    wr_en   = (phase_q == PH_WRITE);
    last_wr = wr_en && (idx_q == LAST_IDX);
    rd_addr = (ADDR_W'(page_q) << IDX_W) | ADDR_W'(idx_q);
  end
endmodule

// File: rtl/sdma_cyccnt.sv
module sdma_cyccnt #(
  parameter int CYC_W = 32,
  parameter int STEP  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  output logic [CYC_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (finish) count <= count + CYC_W'(STEP);
  end
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 256,
  parameter int CYC_W = 32,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              fwd_wr_en,
  output logic [ADDR_W-1:0] fwd_wr_addr,
  output logic [DATA_W-1:0] fwd_wr_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              vid_wr_en,
  output logic [ADDR_W-1:0] vid_wr_addr,
  output logic [DATA_W-1:0] vid_wr_data,
  output logic              cpu_stall,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycle_count
);
  localparam int STEP_CYCLES = 2 * PAGE_BYTES;

  logic hit, active, last_wr;

  sdma_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR)) u_snoop (
    .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .hit(hit), .fwd_wr_en(fwd_wr_en), .fwd_wr_addr(fwd_wr_addr), .fwd_wr_data(fwd_wr_data)
  );

  sdma_seq #(.ADDR_W(ADDR_W), .PAGE_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(hit), .start_page(cpu_wr_data),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .wr_en(vid_wr_en),
    .last_wr(last_wr), .active(active)
  );

  sdma_cyccnt #(.CYC_W(CYC_W), .STEP(STEP_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .finish(last_wr), .count(cycle_count)
  );

  always_comb begin
    vid_wr_addr = DEST_ADDR;
    vid_wr_data = mem_rd_data;
    cpu_stall   = active;
    busy        = active;
    done        = last_wr;
  end
endmodule

// File: rtl/sprite_dma_checker.sv
module sprite_dma_checker #(
  parameter int ADDR_W = 16,
  parameter int CYC_W = 32,
  parameter int PAGE_BYTES = 256,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr_en,
  input logic [ADDR_W-1:0] cpu_wr_addr,
  input logic              fwd_wr_en,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              vid_wr_en,
  input logic [ADDR_W-1:0] vid_wr_addr,
  input logic              cpu_stall,
  input logic              busy,
  input logic              done,
  input logic [CYC_W-1:0]  cycle_count
);
  assert_trigger_not_forwarded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_wr_addr == TRIG_ADDR) |-> !fwd_wr_en);

  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(vid_wr_en)) |-> (mem_rd_addr == $past(mem_rd_addr, 2) + 1'b1));

  assert_dest_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vid_wr_en |-> (vid_wr_addr == DEST_ADDR));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && vid_wr_en));

  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> vid_wr_en);

  assert_stall_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall == busy) && ((mem_rd_en || vid_wr_en) == busy));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cycle_count == $past(cycle_count) + CYC_W'(2 * PAGE_BYTES)));

  assert_done_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vid_wr_en && !$past(done)));
endmodule

bind sprite_dma sprite_dma_checker #(
  .ADDR_W(ADDR_W), .CYC_W(CYC_W), .PAGE_BYTES(PAGE_BYTES),
  .TRIG_ADDR(TRIG_ADDR), .DEST_ADDR(DEST_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
  .fwd_wr_en(fwd_wr_en), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .vid_wr_en(vid_wr_en), .vid_wr_addr(vid_wr_addr), .cpu_stall(cpu_stall),
  .busy(busy), .done(done), .cycle_count(cycle_count)
);

// File: tb/sprite_dma_bench.sv
module sprite_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_wr_addr = '0;
  logic [7:0]  cpu_wr_data = '0;
  logic        fwd_wr_en, mem_rd_en, vid_wr_en, cpu_stall, busy, done;
  logic [15:0] fwd_wr_addr, mem_rd_addr, vid_wr_addr;
  logic [7:0]  fwd_wr_data, vid_wr_data;
  logic [7:0]  mem_rd_data = '0;
  logic [31:0] cycle_count;

  int checks = 0;
  int errors = 0;
  int finished_runs = 0;

  always #5 clk = ~clk;

  sprite_dma u_sprite_dma (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .fwd_wr_en(fwd_wr_en), .fwd_wr_addr(fwd_wr_addr), .fwd_wr_data(fwd_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .vid_wr_en(vid_wr_en), .vid_wr_addr(vid_wr_addr), .vid_wr_data(vid_wr_data),
    .cpu_stall(cpu_stall), .busy(busy), .done(done), .cycle_count(cycle_count)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  // Memory model with one cycle of read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_rd_addr);

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cpu_store(input logic [15:0] a, input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
  endtask

  task automatic run_copy(input logic [7:0] page, input bit poke_mid);
    int reads = 0;
    int writes = 0;
    logic [31:0] base = cycle_count;
    @(negedge clk);
    cpu_store(16'h4014, page);
    #1;
    chk(fwd_wr_en == 1'b0, "R2 trigger not forwarded", fwd_wr_en, 0);
    chk(busy == 1'b0, "R6 idle in trigger cycle", busy, 0);
    for (int c = 1; c <= 512; c++) begin
      @(negedge clk);
      cpu_wr_en = 1'b0;
      if (poke_mid && c == 201) cpu_store(16'h4014, 8'h99);
      #1;
      if (poke_mid && c == 201)
        chk(fwd_wr_en == 1'b0, "R7 mid-copy trigger not forwarded", fwd_wr_en, 0);
      chk(cpu_stall && busy, "R6 stall and busy held", {cpu_stall, busy}, 3);
      if (c % 2 == 1) begin
        reads++;
        chk(mem_rd_en && !vid_wr_en, "R5 read cycle", {mem_rd_en, vid_wr_en}, 2);
        chk(mem_rd_addr == {page, 8'((c - 1) / 2)}, "R3 R7 R10 read address",
            mem_rd_addr, {page, 8'((c - 1) / 2)});
        chk(done == 1'b0, "R9 no done on read", done, 0);
      end else begin
        writes++;
        chk(vid_wr_en && !mem_rd_en, "R5 write cycle", {mem_rd_en, vid_wr_en}, 1);
        chk(vid_wr_addr == 16'h2004, "R4 destination", vid_wr_addr, 16'h2004);
        chk(vid_wr_data == mem_val({page, 8'((c - 2) / 2)}), "R4 R10 write data",
            vid_wr_data, mem_val({page, 8'((c - 2) / 2)}));
        chk(done == (c == 512), "R9 done timing", done, (c == 512));
      end
      chk(cycle_count == base, "R8 count steady during copy", cycle_count, base);
    end
    @(negedge clk);
    cpu_wr_en = 1'b0;
    #1;
    chk(reads == 256 && writes == 256, "R5 transfer count", reads * 1000 + writes, 256256);
    chk(!busy && !cpu_stall && !mem_rd_en && !vid_wr_en, "R6 released after last write",
        {busy, cpu_stall, mem_rd_en, vid_wr_en}, 0);
    chk(done == 1'b0, "R9 done is one cycle", done, 0);
    chk(cycle_count == base + 32'd512, "R8 count step", cycle_count, base + 32'd512);
    finished_runs++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !cpu_stall && !mem_rd_en && !vid_wr_en && !done && cycle_count == 0,
        "R1 reset state", {busy, cpu_stall, mem_rd_en, vid_wr_en, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // Ordinary stores and near misses pass through and start nothing
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = (i == 0) ? 16'h4015 : (i == 1) ? 16'h4013 : (i == 2) ? 16'h2004 : 16'h0514;
      @(negedge clk);
      cpu_store(a, 8'(8'h30 + i));
      #1;
      chk(fwd_wr_en && fwd_wr_addr == a && fwd_wr_data == 8'(8'h30 + i),
          "R2 forward ordinary store", fwd_wr_addr, a);
      @(negedge clk);
      cpu_wr_en = 1'b0;
      #1;
      chk(!busy, "R2 non-trigger starts nothing", busy, 0);
    end
    run_copy(8'h00, 1'b0);
    run_copy(8'h01, 1'b0);
    run_copy(8'h37, 1'b1);
    run_copy(8'h80, 1'b0);
    run_copy(8'hFE, 1'b0);
    run_copy(8'hFF, 1'b1);
    chk(cycle_count == 32'd3072, "R8 total after six copies", cycle_count, 3072);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog runs=%0d actual=hung expected=finished", finished_runs);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule